// File: doc/BRIEF.md
# Serial Flash Power-Up Unprotect Sequencer

This block wakes a serial NOR flash after power-up, removes its default sector write protection, and then returns the part to deep power-down. It drives the three serial lines a controller normally owns: an active-low chip select, a serial clock and a data-out line. It runs a fixed, self-timed command script and never reads anything back. There is no general read, program or erase path.

A one-cycle start pulse launches the script. The block first waits a startup delay counted in ticks of a divided timebase. It then sends six transactions, each inside its own chip-select frame:

1. A release-from-power-down command.
2. A write enable.
3. A status write of zero.
4. A second write enable.
5. A second status write of zero.
6. A deep power-down command.

The first status write unlocks the protection-lock bit. Only the second one can then clear the per-sector protect bits, so both pairs are needed. A busy flag covers the whole run, and a one-cycle done pulse marks its end. Start pulses that arrive while busy are discarded. A start pulse after completion runs the script again.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, and whenever busy is low, `cs_n_o`, `sck_o` and `mosi_o` are all high and `busy_o`/`done_o` are low; no chip-select activity occurs without a start pulse.
- R2: After a start pulse, chip select stays high for at least `STARTUP_TICKS * TICK_DIV` clock cycles before its first falling edge.
- R3: The bytes seen on `mosi_o` at each `sck_o` rising edge while `cs_n_o` is low, most significant bit first, form six frames in this order: `AB` | `06` | `01 00` | `06` | `01 00` | `B9` (hex).
- R4: A frame opens with `cs_n_o` falling while `sck_o` and `mosi_o` are still high; `sck_o` falls in a later cycle.
- R5: A frame closes with `cs_n_o` rising while `sck_o` is low. `sck_o` rises in a later cycle. `mosi_o` does not rise before `sck_o` once chip select is high.
- R6: Inside a frame, every high and low phase of `sck_o` lasts at least `PHASE_CLKS` clock cycles (minimum one).
- R7: Between frames, `cs_n_o` stays high for at least `DESEL_CLKS + GUARD_CLKS` cycles. After the wake frame it stays high for at least `DESEL_CLKS + WAKE_CLKS + GUARD_CLKS` cycles.
- R8: `busy_o` rises in the cycle after an accepted start and stays high through every frame. `done_o` pulses for exactly one cycle, in the cycle where `busy_o` falls, with all three lines high.
- R9: A start pulse while `busy_o` is high is ignored: the run still produces exactly six frames and one done pulse.
- R10: A start pulse after completion runs the full six-frame script again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the script |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| busy_o | output | 1 | High while the script runs |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start request that lands while the sequencer is already running: once in the startup wait and once in the middle of the later frames. The stimulus for that case fires a first start, then a second start a few cycles into the startup delay. It watches the reconstructed frames and fires a third start once two frames have closed. The run must still produce exactly six frames and a single done pulse. A monitor rebuilds each frame bit by bit on the serial-clock rising edges. The same monitor times the chip-select gaps and clock phases, so every run is checked against the command order and the spacing rules.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

    localparam logic [7:0] OP_WAKE      = 8'hAB;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_WR_STATUS = 8'h01;
    localparam logic [7:0] OP_SLEEP     = 8'hB9;
    localparam logic [7:0] STATUS_CLEAR = 8'h00;

    localparam int unsigned SCRIPT_LEN = 6;
    localparam int unsigned TXN_W      = $clog2(SCRIPT_LEN);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BOOT,
        ST_GUARD,
        ST_CS_LO,
        ST_SETUP,
        ST_HIGH,
        ST_CL_CS,
        ST_CL_SCK,
        ST_CL_MOSI,
        ST_DESEL,
        ST_WAKE
    } seq_state_e;

    // Opcode of each frame in the script; order is behaviour.
    function automatic logic [7:0] frame_opcode(input logic [TXN_W-1:0] t);
        logic [7:0] op;
        case (t)
            TXN_W'(0):            op = OP_WAKE;
            TXN_W'(1), TXN_W'(3): op = OP_WR_EN;
            TXN_W'(2), TXN_W'(4): op = OP_WR_STATUS;
            default:              op = OP_SLEEP;
        endcase
        return op;
    endfunction

    function automatic logic frame_has_data(input logic [TXN_W-1:0] t);
        return (t == TXN_W'(2)) || (t == TXN_W'(4));
    endfunction

endpackage

// File: rtl/startup_timer.sv
module startup_timer #(
    parameter int unsigned TICK_DIV      = 4,
    parameter int unsigned STARTUP_TICKS = 10240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned DIV   = (TICK_DIV < 1) ? 1 : TICK_DIV;
    localparam int unsigned PRE_W = $clog2(DIV + 1);
    localparam int unsigned TCK_W = $clog2(STARTUP_TICKS + 2);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
    localparam logic [TCK_W-1:0] TCK_END  = TCK_W'(STARTUP_TICKS);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TCK_W-1:0] ticks;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run_i) begin
            tmr_d.pre   = '0;
            tmr_d.ticks = '0;
        end else if (tmr_q.ticks != TCK_END) begin
            if (tmr_q.pre == PRE_LAST) begin
                tmr_d.pre   = '0;
                tmr_d.ticks = tmr_q.ticks + TCK_W'(1);
            end else begin
                tmr_d.pre = tmr_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = run_i && (tmr_q.ticks == TCK_END);

    // R2: tick count saturates at the startup length and never wraps
    p_tick_saturate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.ticks <= TCK_END);

    // R2: while running, the tick count never goes backwards
    p_tick_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && $past(run_i) |-> tmr_q.ticks >= $past(tmr_q.ticks));

endmodule

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_unlock_pkg::*;
(
    input  logic [TXN_W-1:0] txn_i,
    output logic [7:0]       op_o,
    output logic [7:0]       data_o,
    output logic             two_byte_o,
    output logic             wake_o,
    output logic             last_o
);
    always_comb begin
        op_o       = frame_opcode(txn_i);
        two_byte_o = frame_has_data(txn_i);
        data_o     = STATUS_CLEAR;
        wake_o     = (txn_i == TXN_W'(0));
        last_o     = (txn_i == TXN_W'(SCRIPT_LEN - 1));
    end
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
    import flash_unlock_pkg::*;
#(
    parameter int unsigned TICK_DIV      = 4,
    parameter int unsigned STARTUP_TICKS = 10240,
    parameter int unsigned PHASE_CLKS    = 2,
    parameter int unsigned GUARD_CLKS    = 4,
    parameter int unsigned DESEL_CLKS    = 8,
    parameter int unsigned WAKE_CLKS     = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic cs_n_o,
    output logic sck_o,
    output logic mosi_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned PH = (PHASE_CLKS < 1) ? 1 : PHASE_CLKS;
    localparam int unsigned GD = (GUARD_CLKS < 1) ? 1 : GUARD_CLKS;
    localparam int unsigned DS = (DESEL_CLKS < 1) ? 1 : DESEL_CLKS;
    localparam int unsigned WK = (WAKE_CLKS  < 1) ? 1 : WAKE_CLKS;
    localparam int unsigned M1 = (PH > GD) ? PH : GD;
    localparam int unsigned M2 = (DS > WK) ? DS : WK;
    localparam int unsigned MAX_CNT = (M1 > M2) ? M1 : M2;
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] LD_PH = CNT_W'(PH - 1);
    localparam logic [CNT_W-1:0] LD_GD = CNT_W'(GD - 1);
    localparam logic [CNT_W-1:0] LD_DS = CNT_W'(DS - 1);
    localparam logic [CNT_W-1:0] LD_WK = CNT_W'(WK - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [TXN_W-1:0] txn;
        logic             second;
        logic [2:0]       bitn;
        logic             cs_n;
        logic             sck;
        logic             mosi;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic       boot_done;
    logic [7:0] rom_op, rom_data;
    logic       rom_two, rom_wake, rom_last;
    logic [7:0] cur_byte;
    logic [2:0] nxt_bit;
    logic       cnt_zero;

    startup_timer #(
        .TICK_DIV      (TICK_DIV),
        .STARTUP_TICKS (STARTUP_TICKS)
    ) i_startup_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (seq_q.st == ST_BOOT),
        .expired_o (boot_done)
    );

    flash_cmd_rom i_flash_cmd_rom (
        .txn_i      (seq_q.txn),
        .op_o       (rom_op),
        .data_o     (rom_data),
        .two_byte_o (rom_two),
        .wake_o     (rom_wake),
        .last_o     (rom_last)
    );

    assign cur_byte = seq_q.second ? rom_data : rom_op;
    assign nxt_bit  = seq_q.bitn - 3'd1;
    assign cnt_zero = (seq_q.cnt == '0);

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (!cnt_zero && seq_q.st != ST_IDLE && seq_q.st != ST_BOOT)
            seq_d.cnt = seq_q.cnt - CNT_W'(1);

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.busy = 1'b1;
                    seq_d.txn  = '0;
                    seq_d.st   = ST_BOOT;
                end
            end
            ST_BOOT: begin
                if (boot_done) begin
                    seq_d.cnt = LD_GD;
                    seq_d.st  = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (cnt_zero) begin
                    seq_d.cs_n   = 1'b0;
                    seq_d.second = 1'b0;
                    seq_d.bitn   = 3'd7;
                    seq_d.cnt    = LD_PH;
                    seq_d.st     = ST_CS_LO;
                end
            end
            ST_CS_LO: begin
                if (cnt_zero) begin
                    seq_d.sck  = 1'b0;
                    seq_d.mosi = cur_byte[7];
                    seq_d.cnt  = LD_PH;
                    seq_d.st   = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    seq_d.sck = 1'b1;
                    seq_d.cnt = LD_PH;
                    seq_d.st  = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    seq_d.sck = 1'b0;
                    seq_d.cnt = LD_PH;
                    if (seq_q.bitn != 3'd0) begin
                        seq_d.bitn = nxt_bit;
                        seq_d.mosi = cur_byte[nxt_bit];
                        seq_d.st   = ST_SETUP;
                    end else if (rom_two && !seq_q.second) begin
                        seq_d.second = 1'b1;
                        seq_d.bitn   = 3'd7;
                        seq_d.mosi   = rom_data[7];
                        seq_d.st     = ST_SETUP;
                    end else begin
                        seq_d.st = ST_CL_CS;
                    end
                end
            end
            ST_CL_CS: begin
                if (cnt_zero) begin
                    seq_d.cs_n = 1'b1;
                    seq_d.cnt  = LD_PH;
                    seq_d.st   = ST_CL_SCK;
                end
            end
            ST_CL_SCK: begin
                if (cnt_zero) begin
                    seq_d.sck = 1'b1;
                    seq_d.cnt = LD_PH;
                    seq_d.st  = ST_CL_MOSI;
                end
            end
            ST_CL_MOSI: begin
                if (cnt_zero) begin
                    seq_d.mosi = 1'b1;
                    if (rom_last) begin
                        seq_d.busy = 1'b0;
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end else begin
                        seq_d.cnt = LD_DS;
                        seq_d.st  = ST_DESEL;
                    end
                end
            end
            ST_DESEL: begin
                if (cnt_zero) begin
                    seq_d.txn = seq_q.txn + TXN_W'(1);
                    if (rom_wake) begin
                        seq_d.cnt = LD_WK;
                        seq_d.st  = ST_WAKE;
                    end else begin
                        seq_d.cnt = LD_GD;
                        seq_d.st  = ST_GUARD;
                    end
                end
            end
            ST_WAKE: begin
                if (cnt_zero) begin
                    seq_d.cnt = LD_GD;
                    seq_d.st  = ST_GUARD;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.cs_n <= 1'b1;
            seq_q.sck  <= 1'b1;
            seq_q.mosi <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o = seq_q.cs_n;
    assign sck_o  = seq_q.sck;
    assign mosi_o = seq_q.mosi;
    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;

    // R1: every line idles high while not busy
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o && sck_o && mosi_o);

    // R2: no serial activity during the startup wait
    p_boot_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == ST_BOOT |-> cs_n_o && sck_o);

    // R4: chip select drops while clock and data are still high
    p_open_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> sck_o && mosi_o);

    // R5: chip select rises while the clock is still low
    p_close_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> !sck_o);

    // R5: the clock returns high only after chip select was already high
    p_sck_after_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) && cs_n_o |-> $past(cs_n_o));

    // R8: done lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done coincides with busy falling
    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));

    // R9: once past the startup wait, a run never re-enters it
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st != ST_IDLE && seq_q.st != ST_BOOT |=> seq_q.st != ST_BOOT);

endmodule

// File: tb/test_flash_unlock_seq.sv
module test_flash_unlock_seq;

    localparam int TICK_DIV      = 2;
    localparam int STARTUP_TICKS = 20;
    localparam int PHASE_CLKS    = 2;
    localparam int GUARD_CLKS    = 3;
    localparam int DESEL_CLKS    = 4;
    localparam int WAKE_CLKS     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cs_n, sck, mosi, busy, done;

    always #2 clk = ~clk;

    flash_unlock_seq #(
        .TICK_DIV      (TICK_DIV),
        .STARTUP_TICKS (STARTUP_TICKS),
        .PHASE_CLKS    (PHASE_CLKS),
        .GUARD_CLKS    (GUARD_CLKS),
        .DESEL_CLKS    (DESEL_CLKS),
        .WAKE_CLKS     (WAKE_CLKS)
    ) i_flash_unlock_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .cs_n_o  (cs_n),
        .sck_o   (sck),
        .mosi_o  (mosi),
        .busy_o  (busy),
        .done_o  (done)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0, start_cyc = 0;
    int run_txn = 0, run_done = 0, cs_falls = 0;
    int cs_hi_len = 0, sck_run = 0, nbits = 0;
    logic [15:0] shreg = '0;
    logic p_cs = 1'b1, p_sck = 1'b1, p_mosi = 1'b1, p_busy = 1'b0, p_done = 1'b0;

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input int i);
        case (i)
            0: return 16'h00AB;
            1, 3: return 16'h0006;
            2, 4: return 16'h0100;
            5: return 16'h00B9;
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic int exp_bits(input int i);
        return (i == 2 || i == 4) ? 16 : 8;
    endfunction

    // Port monitor: rebuilds frames and times the serial lines
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (start && !busy) begin
                run_txn = 0; run_done = 0; start_cyc = cyc;
            end
            if (sck != p_sck) begin
                if (!cs_n && !p_cs)
                    chk(sck_run >= PHASE_CLKS, "R6", "sck phase length", sck_run, PHASE_CLKS);
                sck_run = 1;
            end else begin
                sck_run++;
            end
            if (!cs_n && sck && !p_sck) begin
                shreg = {shreg[14:0], mosi};
                nbits++;
            end
            if (!cs_n && p_cs) begin
                chk(sck && mosi, "R4", "sck/mosi at cs fall", {sck, mosi}, 2'b11);
                if (run_txn == 0)
                    chk(cyc - start_cyc >= STARTUP_TICKS * TICK_DIV, "R2", "startup wait",
                        cyc - start_cyc, STARTUP_TICKS * TICK_DIV);
                else if (run_txn == 1)
                    chk(cs_hi_len >= DESEL_CLKS + WAKE_CLKS + GUARD_CLKS, "R7", "gap after wake",
                        cs_hi_len, DESEL_CLKS + WAKE_CLKS + GUARD_CLKS);
                else
                    chk(cs_hi_len >= DESEL_CLKS + GUARD_CLKS, "R7", "deselect gap",
                        cs_hi_len, DESEL_CLKS + GUARD_CLKS);
                nbits = 0; shreg = '0; cs_falls++;
            end
            if (cs_n && !p_cs) begin
                chk(!sck, "R5", "sck at cs rise", sck, 0);
                chk(nbits == exp_bits(run_txn), "R3", "frame bit count", nbits, exp_bits(run_txn));
                chk(shreg == exp_frame(run_txn), "R3", "frame bytes", shreg, exp_frame(run_txn));
                run_txn++;
                cs_hi_len = 0;
            end
            if (cs_n) cs_hi_len++;
            if (cs_n && p_cs && mosi && !p_mosi && !sck)
                chk(1'b0, "R5", "mosi rose before sck", mosi, 0);
            if (!cs_n && !busy)
                chk(1'b0, "R8", "busy low inside frame", busy, 1);
            if (done) begin
                chk(!p_done, "R8", "done width", p_done, 0);
                chk(!busy && p_busy, "R8", "busy fall with done", {p_busy, busy}, 2'b10);
                chk(cs_n && sck && mosi, "R8", "lines at done", {cs_n, sck, mosi}, 3'b111);
                chk(run_txn == 6, "R8", "frames before done", run_txn, 6);
                run_done++;
            end
        end
        p_cs = cs_n; p_sck = sck; p_mosi = mosi; p_busy = busy; p_done = done;
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n && sck && mosi, "R1", "lines after reset", {cs_n, sck, mosi}, 3'b111);
        chk(!busy && !done, "R1", "flags after reset", {busy, done}, 2'b00);
        repeat (50) @(negedge clk);
        chk(cs_falls == 0, "R1", "no frame without start", cs_falls, 0);
    endtask

    task automatic t_run(input bit inject, input string req);
        bit ok;
        int falls0;
        falls0 = cs_falls;
        pulse_start();
        @(negedge clk);
        chk(busy, "R8", "busy after start", busy, 1);
        if (inject) begin
            repeat (5) @(negedge clk);
            pulse_start();
            for (int i = 0; i < 5000 && run_txn < 2; i++) @(negedge clk);
            pulse_start();
        end
        wait_done(ok);
        chk(ok, "R8", "done reached", ok, 1);
        repeat (40) @(negedge clk);
        chk(run_txn == 6, req, "frames in run", run_txn, 6);
        chk(run_done == 1, req, "done pulses in run", run_done, 1);
        chk(cs_falls - falls0 == 6, req, "frame openings", cs_falls - falls0, 6);
        chk(!busy && cs_n && sck && mosi, "R1", "idle after run",
            {busy, cs_n, sck, mosi}, 4'b0111);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_run(1'b0, "R3");   // basic script
        t_run(1'b1, "R9");   // starts while busy are dropped
        t_run(1'b0, "R10");  // rerun after completion
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule